// File: doc/BRIEF.md
# Parallel EEPROM Burst Writer with Completion Polling

This block sits on the host side of a byte-wide parallel EEPROM. It takes one request (a start pulse, a base address, a byte count from 1 to one page, a polling mode and an optional unlock prefix) and carries it out as a train of write strobes on the memory's chip-enable, write-enable and output-enable lines. It then polls the device until the internal programming cycle has finished. Bytes arrive from a simple stream: the block captures `byte_in` whenever it needs the next byte and marks that capture with a one-cycle `byte_take` pulse. The host then moves its stream on by one byte.

Two ways to detect completion are built in. In bit-7 mode the block re-reads the last address written until bit 7 of the returned value matches bit 7 of the last byte stored. In bit-6 mode it keeps reading until two reads in a row return the same bit 6. A request whose bytes would cross a page boundary is refused before any strobe is issued. A polling phase that runs past a set number of cycles ends with a timeout flag. All strobe widths and gaps are parameters counted in clock cycles.

Top module: `eeprw_page_writer`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe`, `busy`, `done`, `byte_take`, `err_range` and `err_timeout` are low.
- R2: Each byte load keeps `mem_ce_n` low and `mem_oe_n` high, and drives `mem_we_n` low for exactly WE_LOW_CYC cycles. Address and data are driven (`mem_dq_oe` high) for at least SETUP_CYC cycles before `mem_we_n` falls.
- R3: Data byte i (counting from 0) is written to address base+i with the i-th stream byte. `byte_take` pulses once per data byte. Every data byte of a request has the same address bits above the page offset (bits 12..6 by default).
- R4: Within a burst, consecutive write-enable falling edges are SETUP_CYC+WE_LOW_CYC+WE_HIGH_CYC cycles apart. This is always below the load window LOAD_WIN_CYC.
- R5: With `unlock_en` set, three writes come before the data, in this order: 0xAA to 0x1555, 0x55 to 0x0AAA, 0xA0 to 0x1555. After the third write's strobe ends, at least UNLOCK_GAP_CYC cycles pass before the next write-enable fall.
- R6: A polling read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high, and puts the last data address on `mem_addr`. `mem_dq_oe` is low in every cycle in which `mem_oe_n` is low.
- R7: With `toggle_mode` = 0, the operation completes on the first polling read whose bit 7 equals bit 7 of the last data byte written.
- R8: With `toggle_mode` = 1, the operation completes on the first polling read whose bit 6 equals bit 6 of the read just before it. The first read of a polling phase never completes.
- R9: A request with `byte_cnt` = 0, or with (base offset within the page) + `byte_cnt` greater than the page size, issues no strobe. It raises `done` together with `err_range` within two cycles of `start`.
- R10: If no completing read has been seen TIMEOUT_CYC cycles after polling begins, the operation ends with `done` and `err_timeout` high.
- R11: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` while busy is ignored. Both error flags hold until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| base_addr | input | ADDR_W | Address of the first data byte |
| byte_cnt | input | PAGE_W+1 | Number of data bytes, 1 to page size |
| unlock_en | input | 1 | Prefix the three-write unlock sequence |
| toggle_mode | input | 1 | 0: bit-7 compare polling, 1: bit-6 stability polling |
| byte_in | input | 8 | Current byte of the data stream |
| byte_take | output | 1 | Pulses when `byte_in` has been captured |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data read from the memory |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_range | output | 1 | Last request was refused for its byte range |
| err_timeout | output | 1 | Last operation ended by polling timeout |

## Verification
Two functions can meet in the same cycle. The first is the sample at the end of a polling read. The second is the moment the polling timeout runs out. If a read completes in the cycle the timer reaches zero, completion must win and no error may be flagged. The bench provokes the timeout side with a memory model that never finishes programming, and it checks that the error then appears close to TIMEOUT_CYC cycles after the last strobe and not earlier. A second meeting point is a new `start` pulse arriving while a burst is under way. The bench judges this case from the write log, which must contain only the first request's addresses.

// File: rtl/eeprw_pkg.sv
package eeprw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RGAP,
    ST_FINISH
  } eeprw_state_e;

  localparam logic [1:0] UNLOCK_LAST = 2'd2;

  // Unlock sequence: the order is behaviour, the device checks it.
  function automatic logic [12:0] unlock_addr(input logic [1:0] step);
    case (step)
      2'd1:    unlock_addr = 13'h0AAA;
      default: unlock_addr = 13'h1555;
    endcase
  endfunction

  function automatic logic [7:0] unlock_data(input logic [1:0] step);
    case (step)
      2'd0:    unlock_data = 8'hAA;
      2'd1:    unlock_data = 8'h55;
      default: unlock_data = 8'hA0;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    max2 = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eeprw_timer.sv
module eeprw_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/eeprw_poll.sv
module eeprw_poll (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample,
  input  logic       toggle_mode,
  input  logic [7:0] rd_data,
  input  logic       ref_bit7,
  output logic       complete
);

  logic prev6_q;
  logic have_q;
  logic prev6_d;
  logic have_d;

  always_comb begin
    if (toggle_mode) begin
      complete = sample && have_q && (rd_data[6] == prev6_q);
    end else begin
      complete = sample && (rd_data[7] == ref_bit7);
    end
  end

  always_comb begin
    prev6_d = prev6_q;
    have_d  = have_q;
    if (clear) begin
      have_d = 1'b0;
    end else if (sample) begin
      have_d  = 1'b1;
      prev6_d = rd_data[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev6_q <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      prev6_q <= prev6_d;
      have_q  <= have_d;
    end
  end

endmodule

// File: rtl/eeprw_page_writer.sv
module eeprw_page_writer
  import eeprw_pkg::*;
#(
  parameter int unsigned ADDR_W         = 13,
  parameter int unsigned PAGE_W         = 6,
  parameter int unsigned SETUP_CYC      = 2,
  parameter int unsigned WE_LOW_CYC     = 6,
  parameter int unsigned WE_HIGH_CYC    = 5,
  parameter int unsigned UNLOCK_GAP_CYC = 50,
  parameter int unsigned READ_CYC       = 4,
  parameter int unsigned READ_GAP_CYC   = 2,
  parameter int unsigned TIMEOUT_CYC    = 600000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [PAGE_W:0]   byte_cnt,
  input  logic              unlock_en,
  input  logic              toggle_mode,
  input  logic [7:0]        byte_in,
  output logic              byte_take,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [7:0]        mem_dq_in,
  output logic              busy,
  output logic              done,
  output logic              err_range,
  output logic              err_timeout
);

  localparam int unsigned CNT_W      = PAGE_W + 1;
  localparam int unsigned SPAN_W     = PAGE_W + 2;
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
  localparam int unsigned PH_MAX     = max2(max2(max2(SETUP_CYC, WE_LOW_CYC),
                                                  max2(WE_HIGH_CYC, UNLOCK_GAP_CYC)),
                                             max2(READ_CYC, READ_GAP_CYC));
  localparam int unsigned PH_W       = $clog2(PH_MAX + 1);
  localparam int unsigned TMO_W      = $clog2(TIMEOUT_CYC + 1);
  localparam logic [SPAN_W-1:0] SPAN_LIM = SPAN_W'(PAGE_BYTES);

  localparam logic [PH_W-1:0] PH_SETUP  = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0] PH_LOW    = PH_W'(WE_LOW_CYC - 1);
  localparam logic [PH_W-1:0] PH_HIGH   = PH_W'(WE_HIGH_CYC - 1);
  localparam logic [PH_W-1:0] PH_UGAP   = PH_W'(UNLOCK_GAP_CYC - 1);
  localparam logic [PH_W-1:0] PH_READ   = PH_W'(READ_CYC - 1);
  localparam logic [PH_W-1:0] PH_RGAP   = PH_W'(READ_GAP_CYC - 1);
  localparam logic [TMO_W-1:0] TMO_LOAD = TMO_W'(TIMEOUT_CYC - 1);

  eeprw_state_e state_q, state_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        step_q, step_d;
  logic              unl_q, unl_d;
  logic              mode_q, mode_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic              take_q, take_d;
  logic              erng_q, erng_d;
  logic              etmo_q, etmo_d;

  logic              ph_load;
  logic [PH_W-1:0]   ph_val;
  logic              ph_zero;
  logic              tmo_load;
  logic              tmo_zero;
  logic              poll_clear;
  logic              poll_sample;
  logic              poll_done;

  logic [SPAN_W-1:0] span;
  logic              req_bad;

  // Page-range check of the incoming request
  always_comb begin
    span    = {2'b00, base_addr[PAGE_W-1:0]} + {1'b0, byte_cnt};
    req_bad = (byte_cnt == '0) || (span > SPAN_LIM);
  end

  eeprw_timer #(.W(PH_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .zero     (ph_zero)
  );

  eeprw_timer #(.W(TMO_W)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmo_load),
    .load_val (TMO_LOAD),
    .zero     (tmo_zero)
  );

  eeprw_poll u_poll (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (poll_clear),
    .sample      (poll_sample),
    .toggle_mode (mode_q),
    .rd_data     (mem_dq_in),
    .ref_bit7    (data_q[7]),
    .complete    (poll_done)
  );

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    cnt_d       = cnt_q;
    step_d      = step_q;
    unl_d       = unl_q;
    mode_d      = mode_q;
    base_d      = base_q;
    addr_d      = addr_q;
    data_d      = data_q;
    take_d      = 1'b0;
    erng_d      = erng_q;
    etmo_d      = etmo_q;
    ph_load     = 1'b0;
    ph_val      = PH_SETUP;
    tmo_load    = 1'b0;
    poll_clear  = 1'b0;
    poll_sample = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          cnt_d  = byte_cnt;
          base_d = base_addr;
          mode_d = toggle_mode;
          erng_d = req_bad;
          etmo_d = 1'b0;
          idx_d  = '0;
          if (req_bad) begin
            state_d = ST_FINISH;
          end else begin
            state_d = ST_WSETUP;
            ph_load = 1'b1;
            ph_val  = PH_SETUP;
            if (unlock_en) begin
              unl_d  = 1'b1;
              step_d = 2'd0;
              addr_d = ADDR_W'(unlock_addr(2'd0));
              data_d = unlock_data(2'd0);
            end else begin
              unl_d  = 1'b0;
              addr_d = base_addr;
              data_d = byte_in;
              take_d = 1'b1;
            end
          end
        end
      end

      ST_WSETUP: begin
        if (ph_zero) begin
          state_d = ST_WPULSE;
          ph_load = 1'b1;
          ph_val  = PH_LOW;
        end
      end

      ST_WPULSE: begin
        if (ph_zero) begin
          state_d = ST_WHOLD;
          ph_load = 1'b1;
          ph_val  = (unl_q && (step_q == UNLOCK_LAST)) ? PH_UGAP : PH_HIGH;
        end
      end

      ST_WHOLD: begin
        if (ph_zero) begin
          if (unl_q) begin
            state_d = ST_WSETUP;
            ph_load = 1'b1;
            ph_val  = PH_SETUP;
            if (step_q != UNLOCK_LAST) begin
              step_d = step_q + 2'd1;
              addr_d = ADDR_W'(unlock_addr(step_q + 2'd1));
              data_d = unlock_data(step_q + 2'd1);
            end else begin
              unl_d  = 1'b0;
              addr_d = base_q;
              data_d = byte_in;
              take_d = 1'b1;
            end
          end else if (idx_q == (cnt_q - 1'b1)) begin
            state_d    = ST_RACC;
            ph_load    = 1'b1;
            ph_val     = PH_READ;
            tmo_load   = 1'b1;
            poll_clear = 1'b1;
          end else begin
            state_d = ST_WSETUP;
            ph_load = 1'b1;
            ph_val  = PH_SETUP;
            idx_d   = idx_q + 1'b1;
            addr_d  = base_q + ADDR_W'(idx_q) + ADDR_W'(1);
            data_d  = byte_in;
            take_d  = 1'b1;
          end
        end
      end

      ST_RACC: begin
        if (ph_zero) begin
          poll_sample = 1'b1;
          if (poll_done) begin
            state_d = ST_FINISH;
          end else if (tmo_zero) begin
            etmo_d  = 1'b1;
            state_d = ST_FINISH;
          end else begin
            state_d = ST_RGAP;
            ph_load = 1'b1;
            ph_val  = PH_RGAP;
          end
        end
      end

      ST_RGAP: begin
        if (ph_zero) begin
          state_d = ST_RACC;
          ph_load = 1'b1;
          ph_val  = PH_READ;
        end
      end

      ST_FINISH: begin
        state_d = ST_IDLE;
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      step_q  <= '0;
      unl_q   <= 1'b0;
      mode_q  <= 1'b0;
      base_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      take_q  <= 1'b0;
      erng_q  <= 1'b0;
      etmo_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      step_q  <= step_d;
      unl_q   <= unl_d;
      mode_q  <= mode_d;
      base_q  <= base_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      take_q  <= take_d;
      erng_q  <= erng_d;
      etmo_q  <= etmo_d;
    end
  end

  // Output decode from the state register
  always_comb begin
    mem_ce_n  = (state_q == ST_IDLE) || (state_q == ST_FINISH);
    mem_oe_n  = (state_q != ST_RACC);
    mem_we_n  = (state_q != ST_WPULSE);
    mem_dq_oe = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) || (state_q == ST_WHOLD);
  end

  assign mem_addr    = addr_q;
  assign mem_dq_out  = data_q;
  assign byte_take   = take_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_FINISH);
  assign err_range   = erng_q;
  assign err_timeout = etmo_q;

endmodule

// File: rtl/eeprw_page_writer_chk.sv
module eeprw_page_writer_chk #(
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned PAGE_W       = 6,
  parameter int unsigned WE_LOW_CYC   = 6,
  parameter int unsigned LOAD_WIN_CYC = 5000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              done,
  input logic              err_range,
  input logic              err_timeout,
  input logic              in_unlock
);

  localparam int unsigned PG_W = ADDR_W - PAGE_W;

  logic [15:0]     low_len_q;
  logic [15:0]     high_len_q;
  logic            seen_data_q;
  logic [PG_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len_q   <= '0;
      high_len_q  <= '0;
      seen_data_q <= 1'b0;
      page_q      <= '0;
    end else begin
      if (!we_n) begin
        low_len_q  <= (low_len_q == 16'hFFFF) ? low_len_q : low_len_q + 16'd1;
        high_len_q <= '0;
        if (!in_unlock) begin
          seen_data_q <= 1'b1;
          page_q      <= addr[ADDR_W-1:PAGE_W];
        end
      end else begin
        low_len_q  <= '0;
        high_len_q <= (high_len_q == 16'hFFFF) ? high_len_q : high_len_q + 16'd1;
        if (!busy) begin
          seen_data_q <= 1'b0;
        end
      end
    end
  end

  assert_we_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n));

  assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (low_len_q == 16'(WE_LOW_CYC)));

  assert_read_bus_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!dq_oe && we_n && !ce_n));

  assert_load_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && seen_data_q && !in_unlock) |-> (32'(high_len_q) < LOAD_WIN_CYC));

  assert_same_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && seen_data_q && !in_unlock) |-> (addr[ADDR_W-1:PAGE_W] == page_q));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  assert_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_range && err_timeout));

endmodule

bind eeprw_page_writer eeprw_page_writer_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_W     (PAGE_W),
  .WE_LOW_CYC (WE_LOW_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce_n        (mem_ce_n),
  .oe_n        (mem_oe_n),
  .we_n        (mem_we_n),
  .dq_oe       (mem_dq_oe),
  .addr        (mem_addr),
  .busy        (busy),
  .done        (done),
  .err_range   (err_range),
  .err_timeout (err_timeout),
  .in_unlock   (unl_q)
);

// File: tb/eeprw_page_writer_test.sv
module eeprw_page_writer_test;

  localparam int SETUP  = 2;
  localparam int WLOW   = 6;
  localparam int WHIGH  = 5;
  localparam int UGAP   = 50;
  localparam int RD     = 4;
  localparam int RGAP   = 2;
  localparam int TMO    = 2000;
  localparam int PROG   = 300;
  localparam int LOGN   = 96;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [12:0] base_addr;
  logic [6:0]  byte_cnt;
  logic        unlock_en;
  logic        toggle_mode;
  logic [7:0]  byte_in;
  logic        byte_take;
  logic        mem_ce_n, mem_oe_n, mem_we_n;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in;
  logic        busy, done, err_range, err_timeout;

  always #10 clk = ~clk;

  eeprw_page_writer #(
    .SETUP_CYC(SETUP), .WE_LOW_CYC(WLOW), .WE_HIGH_CYC(WHIGH),
    .UNLOCK_GAP_CYC(UGAP), .READ_CYC(RD), .READ_GAP_CYC(RGAP), .TIMEOUT_CYC(TMO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .byte_cnt(byte_cnt), .unlock_en(unlock_en), .toggle_mode(toggle_mode),
    .byte_in(byte_in), .byte_take(byte_take), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .busy(busy), .done(done), .err_range(err_range), .err_timeout(err_timeout)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // memory model and monitor state
  logic [7:0]  stream [0:63];
  int          sidx;
  logic [12:0] log_a [0:LOGN-1];
  logic [7:0]  log_d [0:LOGN-1];
  int          wrise [0:LOGN-1];
  int          wfall [0:LOGN-1];
  int          nlog, nfall, ntake, lowlen, low_min, low_max, dq_run, setup_min;
  int          prog_left, last_wr_cyc, viol;
  logic [12:0] last_a;
  logic [7:0]  last_d;
  logic        tog, forever_busy, prev_we, prev_oe;
  int          done_cyc, start_cyc;
  logic        busy_after_start;

  always @(posedge clk) cyc <= cyc + 1;

  assign byte_in = stream[sidx[5:0]];

  function automatic logic [7:0] lookup(input logic [12:0] a);
    logic [7:0] v;
    v = 8'hFF;
    for (int i = 0; i < LOGN; i++) begin
      if (i < nlog && log_a[i] == a) v = log_d[i];
    end
    return v;
  endfunction

  always @* begin
    if (forever_busy || prog_left != 0) mem_dq_in = {~last_d[7], tog, last_d[5:0]};
    else mem_dq_in = lookup(mem_addr);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_we && !mem_we_n) begin
        if (nfall < LOGN) wfall[nfall] = cyc;
        nfall++;
        lowlen = 0;
        if (dq_run < setup_min) setup_min = dq_run;
      end
      if (!mem_we_n) lowlen++;
      if (!prev_we && mem_we_n && !mem_ce_n) begin
        if (nlog < LOGN) begin
          log_a[nlog] = mem_addr;
          log_d[nlog] = mem_dq_out;
          wrise[nlog] = cyc;
        end
        nlog++;
        last_a = mem_addr;
        last_d = mem_dq_out;
        last_wr_cyc = cyc;
        prog_left = PROG;
        if (lowlen < low_min) low_min = lowlen;
        if (lowlen > low_max) low_max = lowlen;
      end else if (prog_left > 0) begin
        prog_left--;
      end
      if (prev_oe && !mem_oe_n && (forever_busy || prog_left != 0)) tog = ~tog;
      if (!mem_oe_n && mem_dq_oe) viol++;
      if (!mem_oe_n && (!mem_we_n || mem_ce_n || mem_addr != last_a)) viol++;
      if (!mem_we_n && (mem_ce_n || !mem_oe_n)) viol++;
      if (mem_dq_oe) dq_run++; else dq_run = 0;
      if (byte_take) begin
        sidx++;
        ntake++;
      end
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic clear_log(input int seed);
    nlog = 0; nfall = 0; ntake = 0; sidx = 0; viol = 0;
    low_min = 1000; low_max = 0; setup_min = 1000;
    for (int i = 0; i < 64; i++) stream[i] = 8'(seed * 37 + i * 13 + 5);
  endtask

  task automatic run_op(input logic [12:0] b, input logic [6:0] c, input bit unl, input bit tm, input int seed);
    int n;
    clear_log(seed);
    @(negedge clk);
    base_addr = b; byte_cnt = c; unlock_en = unl; toggle_mode = tm; start = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    busy_after_start = busy;
    n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
    end
    done_cyc = cyc;
  endtask

  task automatic t_reset();
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes high", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !byte_take, "R1", "bus idle", {mem_dq_oe, byte_take}, 0);
    chk(!busy && !done && !err_range && !err_timeout, "R1", "status low",
        {busy, done, err_range, err_timeout}, 0);
  endtask

  task automatic t_single_datapoll();
    run_op(13'h0123, 7'd1, 1'b0, 1'b0, 1);
    chk(done, "R7", "done seen", done, 1);
    chk(busy_after_start, "R11", "busy after start", busy_after_start, 1);
    chk(nlog == 1, "R3", "write count", nlog, 1);
    chk(log_a[0] == 13'h0123, "R3", "address", log_a[0], 13'h0123);
    chk(log_d[0] == stream[0], "R3", "data", log_d[0], stream[0]);
    chk(ntake == 1, "R3", "byte_take count", ntake, 1);
    chk(low_min == WLOW && low_max == WLOW, "R2", "we low width", low_max, WLOW);
    chk(setup_min >= SETUP, "R2", "setup before we fall", setup_min, SETUP);
    chk(done_cyc - last_wr_cyc >= PROG, "R7", "done not before ready", done_cyc - last_wr_cyc, PROG);
    chk(done_cyc - last_wr_cyc <= PROG + 30, "R7", "done soon after ready", done_cyc - last_wr_cyc, PROG);
    chk(viol == 0, "R6", "read cycle strobes/bus", viol, 0);
    chk(!err_range && !err_timeout, "R11", "no error flags", {err_range, err_timeout}, 0);
    @(negedge clk);
    chk(!done && !busy, "R11", "done single pulse", {done, busy}, 0);
  endtask

  task automatic t_unlock_toggle();
    int bad;
    run_op(13'h0238, 7'd8, 1'b1, 1'b1, 2);
    chk(nlog == 11, "R5", "write count with prefix", nlog, 11);
    chk(log_a[0] == 13'h1555 && log_d[0] == 8'hAA, "R5", "unlock 1", log_d[0], 8'hAA);
    chk(log_a[1] == 13'h0AAA && log_d[1] == 8'h55, "R5", "unlock 2", log_d[1], 8'h55);
    chk(log_a[2] == 13'h1555 && log_d[2] == 8'hA0, "R5", "unlock 3", log_d[2], 8'hA0);
    chk(wfall[3] - wrise[2] >= UGAP, "R5", "gap after prefix", wfall[3] - wrise[2], UGAP);
    bad = 0;
    for (int i = 0; i < 8; i++)
      if (log_a[3 + i] != 13'h0238 + 13'(i) || log_d[3 + i] != stream[i]) bad++;
    chk(bad == 0, "R3", "burst contents", bad, 0);
    chk(ntake == 8, "R3", "byte_take count", ntake, 8);
    chk(done_cyc - last_wr_cyc >= PROG, "R8", "toggle done not before ready", done_cyc - last_wr_cyc, PROG);
    chk(done_cyc - last_wr_cyc <= PROG + 40, "R8", "toggle done soon after ready", done_cyc - last_wr_cyc, PROG);
    chk(viol == 0, "R6", "read cycle strobes/bus", viol, 0);
  endtask

  task automatic t_full_page();
    int bad, sp;
    run_op(13'h0400, 7'd64, 1'b0, 1'b0, 3);
    chk(nlog == 64, "R3", "full page count", nlog, 64);
    bad = 0;
    for (int i = 0; i < 64; i++)
      if (log_a[i] != 13'h0400 + 13'(i) || log_d[i] != stream[i] || log_a[i][12:6] != 7'h10) bad++;
    chk(bad == 0, "R3", "full page contents", bad, 0);
    sp = 0;
    for (int i = 1; i < 64; i++)
      if (wfall[i] - wfall[i - 1] != SETUP + WLOW + WHIGH) sp++;
    chk(sp == 0, "R4", "load spacing", sp, 0);
    chk(done && !err_range && !err_timeout, "R7", "page completes", {done, err_range, err_timeout}, 4);
  endtask

  task automatic t_range(input logic [12:0] b, input logic [6:0] c, input string what);
    run_op(b, c, 1'b0, 1'b0, 4);
    chk(done && err_range, {"R9 ", what}, "error done", {done, err_range}, 3);
    chk(done_cyc - start_cyc <= 2, "R9", "error latency", done_cyc - start_cyc, 2);
    chk(nfall == 0, "R9", "no strobe issued", nfall, 0);
  endtask

  task automatic t_timeout();
    forever_busy = 1'b1;
    run_op(13'h0700, 7'd2, 1'b0, 1'b0, 5);
    chk(done && err_timeout && !err_range, "R10", "timeout flag", {done, err_timeout, err_range}, 6);
    chk(done_cyc - last_wr_cyc >= TMO, "R10", "timeout not early", done_cyc - last_wr_cyc, TMO);
    chk(done_cyc - last_wr_cyc <= TMO + 40, "R10", "timeout not late", done_cyc - last_wr_cyc, TMO);
    forever_busy = 1'b0;
    repeat (PROG + 5) @(negedge clk);
    chk(err_timeout, "R11", "error flag holds", err_timeout, 1);
  endtask

  task automatic t_busy_ignore();
    int n, bad;
    clear_log(6);
    @(negedge clk);
    base_addr = 13'h0050; byte_cnt = 7'd4; unlock_en = 1'b0; toggle_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!err_timeout, "R11", "error cleared on start", err_timeout, 0);
    repeat (20) @(negedge clk);
    base_addr = 13'h1000; byte_cnt = 7'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
    end
    bad = 0;
    for (int i = 0; i < 4; i++) if (log_a[i] != 13'h0050 + 13'(i)) bad++;
    chk(nlog == 4 && bad == 0, "R11", "start while busy ignored", nlog, 4);
    repeat (3) @(negedge clk);
    chk(!busy && nlog == 4, "R11", "no second operation", nlog, 4);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; base_addr = '0; byte_cnt = '0;
    unlock_en = 1'b0; toggle_mode = 1'b0;
    prev_we = 1'b1; prev_oe = 1'b1; tog = 1'b0; forever_busy = 1'b0;
    prog_left = 0; last_a = '0; last_d = '0; last_wr_cyc = 0;
    clear_log(0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_datapoll();
    t_unlock_toggle();
    t_full_page();
    t_range(13'h0239, 7'd8, "page crossing");
    t_range(13'h0100, 7'd0, "zero count");
    t_range(13'h0100, 7'd65, "count above page");
    t_timeout();
    t_busy_ignore();
    finish_run();
  end

endmodule